// File: doc/BRIEF.md
# Privileged Trap-Return State Updater

This block computes the architectural effect of the two trap-return instructions, supervisor return and machine return, in a core with an optional hypervisor extension. Each cycle it looks at a pair of one-cycle request strobes, the current privilege level, the current virtualization flag and the status fields that a return consumes. One clock edge after a legal request it presents the complete set of updated status fields, the new privilege level and the new virtualization flag. It also presents a one-cycle commit strobe and, when the hart re-enters a guest, a one-cycle request to exchange the guest and host register banks. An illegal return produces a one-cycle illegal-instruction strobe and leaves every state output untouched.

The surrounding status-register file consumes the result. `commit_o` acts as a valid with no ready: the consumer must write the presented values in the cycle the strobe is high, because the block offers no back-pressure and does not queue a second result. Between commits the state outputs hold the last committed values. The hypervisor variant is chosen by the `HAS_HYP` parameter. A pin selects between the current and the legacy interrupt-enable placement.

Privilege codes are 2 bits: 0 user, 1 supervisor, 3 machine, and 2 is reserved. The interrupt-enable field `nxt_ie_o` holds one bit per privilege code, and bit k belongs to privilege k.

Top module: `xret_update`

## Requirements
- R1: A legal request raises `commit_o` for exactly the next cycle. With no request, `commit_o`, `illegal_o` and `swap_o` stay low the next cycle, and all state outputs keep their values.
- R2: A supervisor return with the current privilege at user (0) raises `illegal_o` the next cycle. In that cycle `commit_o` and `swap_o` stay low and the state outputs keep their values.
- R3: A machine return with the current privilege other than machine (3) raises `illegal_o` the next cycle. In that cycle `commit_o` and `swap_o` stay low and the state outputs keep their values.
- R4: When both requests are high in one cycle, only the machine return is evaluated, and it alone decides legality.
- R5: A legal machine return sets the privilege to the old machine-previous-privilege field. It sets the machine-previous-enable bit to 1, clears the machine-previous-privilege field to user (0) and clears the machine-previous-virtualization bit.
- R6: With `HAS_HYP`=1, a legal machine return sets the virtualization flag to the old machine-previous-virtualization bit and pulses `swap_o` exactly when that bit was 1. With `HAS_HYP`=0 the flag follows `cur_virt_i` and `swap_o` stays low.
- R7: Take a legal supervisor return with `HAS_HYP`=0, or with `cur_virt_i`=1. It sets the privilege to {0, old supervisor-previous-privilege bit} and sets the supervisor-previous-enable bit to 1. It clears the supervisor-previous-privilege bit, keeps the virtualization flag and leaves `swap_o` low.
- R8: Take a legal supervisor return with `HAS_HYP`=1 and `cur_virt_i`=0. It sets the privilege to {0, old supervisor-previous-privilege bit} and the virtualization flag to the old first-level previous-virtualization bit. It moves both second-level bits into the first level and clears the second level. It sets `nxt_ie_o[1]` to the old supervisor-previous-enable bit and then sets that previous-enable bit to 1. It pulses `swap_o` exactly when the old first-level previous-virtualization bit was 1.
- R9: The bit of `nxt_ie_o` written by a return depends on `spec_new_i`. With `spec_new_i`=1 it is bit 1 for a supervisor return and bit 3 for a machine return. With `spec_new_i`=0 it is the bit indexed by the previous privilege: the old supervisor-previous-privilege bit for a supervisor return, or the old machine-previous-privilege field for a machine return. The R8 path always writes bit 1. The written bit takes the old previous-enable bit, and the other bits of `nxt_ie_o` take `cur_ie_i`.
- R10: While `rst_n` is low, `commit_o`, `illegal_o` and `swap_o` are 0, `nxt_priv_o` is 3, and every other state output is 0.
- R11: On a commit, every status field that R5 to R9 do not name takes its current input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sret_req_i | input | 1 | Supervisor-return request strobe |
| mret_req_i | input | 1 | Machine-return request strobe |
| spec_new_i | input | 1 | 1 selects current enable-bit placement, 0 legacy shifted placement |
| cur_priv_i | input | 2 | Current privilege level |
| cur_virt_i | input | 1 | Current virtualization flag |
| cur_ie_i | input | 4 | Current per-privilege interrupt enables |
| cur_spie_i | input | 1 | Supervisor-previous interrupt enable |
| cur_spp_i | input | 1 | Supervisor-previous privilege |
| cur_mpie_i | input | 1 | Machine-previous interrupt enable |
| cur_mpp_i | input | 2 | Machine-previous privilege |
| cur_mpv_i | input | 1 | Machine-previous virtualization |
| cur_spv_i | input | 1 | First-level supervisor-previous virtualization |
| cur_sp2v_i | input | 1 | Second-level previous virtualization |
| cur_sp2p_i | input | 1 | Second-level previous privilege |
| commit_o | output | 1 | One-cycle valid for the state outputs |
| illegal_o | output | 1 | One-cycle illegal-instruction strobe |
| swap_o | output | 1 | One-cycle register-bank swap request |
| nxt_priv_o | output | 2 | New privilege level |
| nxt_virt_o | output | 1 | New virtualization flag |
| nxt_ie_o | output | 4 | New per-privilege interrupt enables |
| nxt_spie_o | output | 1 | New supervisor-previous interrupt enable |
| nxt_spp_o | output | 1 | New supervisor-previous privilege |
| nxt_mpie_o | output | 1 | New machine-previous interrupt enable |
| nxt_mpp_o | output | 2 | New machine-previous privilege |
| nxt_mpv_o | output | 1 | New machine-previous virtualization |
| nxt_spv_o | output | 1 | New first-level previous virtualization |
| nxt_sp2v_o | output | 1 | New second-level previous virtualization |
| nxt_sp2p_o | output | 1 | New second-level previous privilege |

## Verification
The assertions assume that the request strobes and status inputs settle before each rising edge and describe the state in the cycle the request is seen. They also assume that any input combination may occur, including the reserved privilege code and both strobes at once. The stimulus drives every input on the falling edge, so each vector is stable around the sampling edge. It walks all combinations of requests, privilege, virtualization, enable-placement mode and status bits, with two complementary enable patterns, on a hypervisor and a non-hypervisor instance side by side.

// File: rtl/xret_pkg.sv
package xret_pkg;

  localparam int PRIV_W = 2;
  localparam int IE_W   = 1 << PRIV_W;

  typedef logic [PRIV_W-1:0] priv_t;

  localparam priv_t PRIV_U = priv_t'(0);
  localparam priv_t PRIV_S = priv_t'(1);
  localparam priv_t PRIV_M = priv_t'(3);

  // Status fields consumed and produced by a trap return.
  typedef struct packed {
    logic [IE_W-1:0] ie;
    logic            spie;
    logic            spp;
    logic            mpie;
    priv_t           mpp;
    logic            mpv;
    logic            spv;
    logic            sp2v;
    logic            sp2p;
  } xstat_t;

  // Which return path was selected this cycle.
  typedef enum logic [1:0] {
    XR_NONE       = 2'd0,
    XR_SRET_PLAIN = 2'd1,
    XR_SRET_HYP   = 2'd2,
    XR_MRET       = 2'd3
  } xret_kind_e;

  // Complete outcome of one return path.
  typedef struct packed {
    xstat_t st;
    priv_t  priv;
    logic   virt;
    logic   swap;
  } xret_result_t;

endpackage

// File: rtl/xret_arbiter.sv
module xret_arbiter
  import xret_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic       sret_i,
  input  logic       mret_i,
  input  priv_t      priv_i,
  input  logic       virt_i,
  output xret_kind_e kind_o,
  output logic       illegal_o
);

  logic sret_legal;
  logic mret_legal;
  logic hyp_path;

  // Supervisor return needs at least supervisor privilege.
  assign sret_legal = (priv_i != PRIV_U);
  // Machine return needs exactly machine privilege.
  assign mret_legal = (priv_i == PRIV_M);
  // Two-level pop applies only when the extension exists and the hart runs as host.
  assign hyp_path   = HAS_HYP && !virt_i;

  always_comb begin
    kind_o    = XR_NONE;
    illegal_o = 1'b0;
    if (mret_i) begin
      // Machine return wins over a simultaneous supervisor return.
      if (mret_legal) kind_o = XR_MRET;
      else            illegal_o = 1'b1;
    end else if (sret_i) begin
      if (!sret_legal)   illegal_o = 1'b1;
      else if (hyp_path) kind_o = XR_SRET_HYP;
      else               kind_o = XR_SRET_PLAIN;
    end
  end

endmodule

// File: rtl/xret_sret_unit.sv
module xret_sret_unit
  import xret_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  xstat_t       cur_i,
  input  logic         virt_i,
  input  logic         spec_new_i,
  output xret_result_t plain_o,
  output xret_result_t hyp_o
);

  priv_t prev_priv;
  priv_t ie_sel;

  assign prev_priv = {{(PRIV_W-1){1'b0}}, cur_i.spp};
  // Legacy placement shifts the user enable by the previous privilege.
  assign ie_sel    = spec_new_i ? PRIV_S : prev_priv;

  always_comb begin
    plain_o            = '0;
    plain_o.st         = cur_i;
    plain_o.st.ie[ie_sel] = cur_i.spie;
    plain_o.st.spie    = 1'b1;
    plain_o.st.spp     = 1'b0;
    plain_o.priv       = prev_priv;
    plain_o.virt       = virt_i;
    plain_o.swap       = 1'b0;
  end

  generate
    if (HAS_HYP) begin : g_hyp
      always_comb begin
        hyp_o             = '0;
        hyp_o.st          = cur_i;
        // Pop the second level into the first, then empty the second.
        hyp_o.st.spv      = cur_i.sp2v;
        hyp_o.st.spp      = cur_i.sp2p;
        hyp_o.st.sp2v     = 1'b0;
        hyp_o.st.sp2p     = 1'b0;
        hyp_o.st.ie[PRIV_S] = cur_i.spie;
        hyp_o.st.spie     = 1'b1;
        hyp_o.priv        = prev_priv;
        hyp_o.virt        = cur_i.spv;
        hyp_o.swap        = cur_i.spv;
      end
    end else begin : g_nohyp
      assign hyp_o = '0;
    end
  endgenerate

endmodule

// File: rtl/xret_mret_unit.sv
module xret_mret_unit
  import xret_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  xstat_t       cur_i,
  input  logic         virt_i,
  input  logic         spec_new_i,
  output xret_result_t res_o
);

  priv_t ie_sel;

  assign ie_sel = spec_new_i ? PRIV_M : cur_i.mpp;

  always_comb begin
    res_o               = '0;
    res_o.st            = cur_i;
    res_o.st.ie[ie_sel] = cur_i.mpie;
    res_o.st.mpie       = 1'b1;
    res_o.st.mpp        = PRIV_U;
    res_o.st.mpv        = 1'b0;
    res_o.priv          = cur_i.mpp;
    // Without the extension the virtualization flag is not touched.
    res_o.virt          = HAS_HYP ? cur_i.mpv : virt_i;
    res_o.swap          = HAS_HYP && cur_i.mpv;
  end

endmodule

// File: rtl/xret_commit.sv
module xret_commit
  import xret_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  xret_kind_e   kind_i,
  input  logic         illegal_i,
  input  xret_result_t plain_i,
  input  xret_result_t hyp_i,
  input  xret_result_t mret_res_i,
  output xstat_t       st_o,
  output priv_t        priv_o,
  output logic         virt_o,
  output logic         swap_o,
  output logic         commit_o,
  output logic         illegal_o
);

  xret_result_t sel;
  logic         take;
  xstat_t       st_q;
  priv_t        priv_q;
  logic         virt_q;
  logic         swap_q;
  logic         commit_q;
  logic         illegal_q;

  always_comb begin
    case (kind_i)
      XR_SRET_PLAIN: sel = plain_i;
      XR_SRET_HYP:   sel = hyp_i;
      XR_MRET:       sel = mret_res_i;
      default:       sel = '0;
    endcase
  end

  assign take = (kind_i != XR_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      priv_q    <= PRIV_M;
      virt_q    <= 1'b0;
      swap_q    <= 1'b0;
      commit_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      commit_q  <= take;
      illegal_q <= illegal_i;
      swap_q    <= take && sel.swap;
      if (take) begin
        st_q   <= sel.st;
        priv_q <= sel.priv;
        virt_q <= sel.virt;
      end
    end
  end

  assign st_o      = st_q;
  assign priv_o    = priv_q;
  assign virt_o    = virt_q;
  assign swap_o    = swap_q;
  assign commit_o  = commit_q;
  assign illegal_o = illegal_q;

  // R6: a bank swap is only ever requested together with a commit.
  assert_swap_with_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |-> commit_q);

  // R1: state only moves on a commit.
  assert_hold_without_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_q |-> ($stable(st_q) && $stable(priv_q) && $stable(virt_q)));

  // R2 / R3: illegal and commit never coincide.
  assert_illegal_excl_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_q && commit_q));

endmodule

// File: rtl/xret_update.sv
module xret_update
  import xret_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sret_req_i,
  input  logic       mret_req_i,
  input  logic       spec_new_i,
  input  logic [1:0] cur_priv_i,
  input  logic       cur_virt_i,
  input  logic [3:0] cur_ie_i,
  input  logic       cur_spie_i,
  input  logic       cur_spp_i,
  input  logic       cur_mpie_i,
  input  logic [1:0] cur_mpp_i,
  input  logic       cur_mpv_i,
  input  logic       cur_spv_i,
  input  logic       cur_sp2v_i,
  input  logic       cur_sp2p_i,
  output logic       commit_o,
  output logic       illegal_o,
  output logic       swap_o,
  output logic [1:0] nxt_priv_o,
  output logic       nxt_virt_o,
  output logic [3:0] nxt_ie_o,
  output logic       nxt_spie_o,
  output logic       nxt_spp_o,
  output logic       nxt_mpie_o,
  output logic [1:0] nxt_mpp_o,
  output logic       nxt_mpv_o,
  output logic       nxt_spv_o,
  output logic       nxt_sp2v_o,
  output logic       nxt_sp2p_o
);

  xstat_t       cur_st;
  xstat_t       nxt_st;
  xret_kind_e   kind;
  logic         illegal_now;
  xret_result_t plain_res;
  xret_result_t hyp_res;
  xret_result_t mret_res;

  always_comb begin
    cur_st.ie   = cur_ie_i;
    cur_st.spie = cur_spie_i;
    cur_st.spp  = cur_spp_i;
    cur_st.mpie = cur_mpie_i;
    cur_st.mpp  = cur_mpp_i;
    cur_st.mpv  = cur_mpv_i;
    cur_st.spv  = cur_spv_i;
    cur_st.sp2v = cur_sp2v_i;
    cur_st.sp2p = cur_sp2p_i;
  end

  xret_arbiter #(.HAS_HYP(HAS_HYP)) u_arb (
    .sret_i    (sret_req_i),
    .mret_i    (mret_req_i),
    .priv_i    (cur_priv_i),
    .virt_i    (cur_virt_i),
    .kind_o    (kind),
    .illegal_o (illegal_now)
  );

  xret_sret_unit #(.HAS_HYP(HAS_HYP)) u_sret (
    .cur_i      (cur_st),
    .virt_i     (cur_virt_i),
    .spec_new_i (spec_new_i),
    .plain_o    (plain_res),
    .hyp_o      (hyp_res)
  );

  xret_mret_unit #(.HAS_HYP(HAS_HYP)) u_mret (
    .cur_i      (cur_st),
    .virt_i     (cur_virt_i),
    .spec_new_i (spec_new_i),
    .res_o      (mret_res)
  );

  xret_commit u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_i     (kind),
    .illegal_i  (illegal_now),
    .plain_i    (plain_res),
    .hyp_i      (hyp_res),
    .mret_res_i (mret_res),
    .st_o       (nxt_st),
    .priv_o     (nxt_priv_o),
    .virt_o     (nxt_virt_o),
    .swap_o     (swap_o),
    .commit_o   (commit_o),
    .illegal_o  (illegal_o)
  );

  assign nxt_ie_o   = nxt_st.ie;
  assign nxt_spie_o = nxt_st.spie;
  assign nxt_spp_o  = nxt_st.spp;
  assign nxt_mpie_o = nxt_st.mpie;
  assign nxt_mpp_o  = nxt_st.mpp;
  assign nxt_mpv_o  = nxt_st.mpv;
  assign nxt_spv_o  = nxt_st.spv;
  assign nxt_sp2v_o = nxt_st.sp2v;
  assign nxt_sp2p_o = nxt_st.sp2p;

  // R1: no request means no strobe of any kind.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sret_req_i && !mret_req_i) |=> (!commit_o && !illegal_o && !swap_o));

  // R2: supervisor return from user privilege is illegal.
  assert_sret_user_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_req_i && !mret_req_i && cur_priv_i == 2'd0)
      |=> (illegal_o && !commit_o && !swap_o && $stable(nxt_priv_o)));

  // R3: machine return below machine privilege is illegal.
  assert_mret_low_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req_i && cur_priv_i != 2'd3)
      |=> (illegal_o && !commit_o && !swap_o && $stable(nxt_virt_o)));

  // R4: with both strobes, supervisor fields are passed through untouched.
  assert_mret_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req_i && sret_req_i && cur_priv_i == 2'd3)
      |=> (commit_o && nxt_spp_o == $past(cur_spp_i) && nxt_spie_o == $past(cur_spie_i)));

  // R5: legal machine return privilege and previous-field effects.
  assert_mret_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req_i && cur_priv_i == 2'd3)
      |=> (nxt_priv_o == $past(cur_mpp_i) && nxt_mpp_o == 2'd0 && !nxt_mpv_o && nxt_mpie_o));

  // R7: supervisor return on the plain path.
  assert_sret_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_req_i && !mret_req_i && cur_priv_i != 2'd0 && (!HAS_HYP || cur_virt_i))
      |=> (nxt_priv_o == {1'b0, $past(cur_spp_i)} && !nxt_spp_o && nxt_spie_o
           && nxt_virt_o == $past(cur_virt_i) && !swap_o));

  // R8: supervisor return on the two-level pop path.
  assert_sret_hyp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_HYP && sret_req_i && !mret_req_i && cur_priv_i != 2'd0 && !cur_virt_i)
      |=> (nxt_virt_o == $past(cur_spv_i) && swap_o == $past(cur_spv_i)
           && nxt_spv_o == $past(cur_sp2v_i) && !nxt_sp2v_o && !nxt_sp2p_o));

endmodule

// File: tb/test_xret_update.sv
module test_xret_update;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sret_req, mret_req, spec_new;
  logic [1:0] cur_priv;
  logic       cur_virt;
  logic [3:0] cur_ie;
  logic       cur_spie, cur_spp, cur_mpie;
  logic [1:0] cur_mpp;
  logic       cur_mpv, cur_spv, cur_sp2v, cur_sp2p;

  logic       h_commit, h_illegal, h_swap, h_virt, h_spie, h_spp, h_mpie, h_mpv, h_spv, h_sp2v, h_sp2p;
  logic [1:0] h_priv, h_mpp;
  logic [3:0] h_ie;
  logic       n_commit, n_illegal, n_swap, n_virt, n_spie, n_spp, n_mpie, n_mpv, n_spv, n_sp2v, n_sp2p;
  logic [1:0] n_priv, n_mpp;
  logic [3:0] n_ie;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xret_update #(.HAS_HYP(1'b1)) i_xret_update (
    .clk(clk), .rst_n(rst_n), .sret_req_i(sret_req), .mret_req_i(mret_req), .spec_new_i(spec_new),
    .cur_priv_i(cur_priv), .cur_virt_i(cur_virt), .cur_ie_i(cur_ie), .cur_spie_i(cur_spie),
    .cur_spp_i(cur_spp), .cur_mpie_i(cur_mpie), .cur_mpp_i(cur_mpp), .cur_mpv_i(cur_mpv),
    .cur_spv_i(cur_spv), .cur_sp2v_i(cur_sp2v), .cur_sp2p_i(cur_sp2p),
    .commit_o(h_commit), .illegal_o(h_illegal), .swap_o(h_swap), .nxt_priv_o(h_priv),
    .nxt_virt_o(h_virt), .nxt_ie_o(h_ie), .nxt_spie_o(h_spie), .nxt_spp_o(h_spp),
    .nxt_mpie_o(h_mpie), .nxt_mpp_o(h_mpp), .nxt_mpv_o(h_mpv), .nxt_spv_o(h_spv),
    .nxt_sp2v_o(h_sp2v), .nxt_sp2p_o(h_sp2p));

  xret_update #(.HAS_HYP(1'b0)) i_xret_update_noh (
    .clk(clk), .rst_n(rst_n), .sret_req_i(sret_req), .mret_req_i(mret_req), .spec_new_i(spec_new),
    .cur_priv_i(cur_priv), .cur_virt_i(cur_virt), .cur_ie_i(cur_ie), .cur_spie_i(cur_spie),
    .cur_spp_i(cur_spp), .cur_mpie_i(cur_mpie), .cur_mpp_i(cur_mpp), .cur_mpv_i(cur_mpv),
    .cur_spv_i(cur_spv), .cur_sp2v_i(cur_sp2v), .cur_sp2p_i(cur_sp2p),
    .commit_o(n_commit), .illegal_o(n_illegal), .swap_o(n_swap), .nxt_priv_o(n_priv),
    .nxt_virt_o(n_virt), .nxt_ie_o(n_ie), .nxt_spie_o(n_spie), .nxt_spp_o(n_spp),
    .nxt_mpie_o(n_mpie), .nxt_mpp_o(n_mpp), .nxt_mpv_o(n_mpv), .nxt_spv_o(n_spv),
    .nxt_sp2v_o(n_sp2v), .nxt_sp2p_o(n_sp2p));

  // Packed view: {commit, illegal, swap, priv[1:0], virt, ie[3:0], spie, spp, mpie, mpp[1:0], mpv, spv, sp2v, sp2p}
  logic [18:0] act_h, act_n;
  assign act_h = {h_commit, h_illegal, h_swap, h_priv, h_virt, h_ie, h_spie, h_spp, h_mpie, h_mpp, h_mpv, h_spv, h_sp2v, h_sp2p};
  assign act_n = {n_commit, n_illegal, n_swap, n_priv, n_virt, n_ie, n_spie, n_spp, n_mpie, n_mpp, n_mpv, n_spv, n_sp2v, n_sp2p};

  logic [15:0] held_h, held_n;
  logic [18:0] exp_h, exp_n;
  string       pend_tag;

  task automatic check(input logic [18:0] act, input logic [18:0] expv, input string tag, input string who);
    tests++;
    if (act !== expv) begin
      failed++;
      $display("FAIL %s (%s): actual %05h expected %05h", tag, who, act, expv);
    end
  endtask

  // Reference outcome computed from the requirement text.
  task automatic model(input bit hh, inout logic [15:0] held, output logic [18:0] expv);
    logic c, il, sw;
    logic [1:0] p, mpp;
    logic v, spie, spp, mpie, mpv, spv, sp2v, sp2p;
    logic [3:0] ie;
    int k;
    c = 0; il = 0; sw = 0;
    p = cur_priv; v = cur_virt; ie = cur_ie; spie = cur_spie; spp = cur_spp; mpie = cur_mpie;
    mpp = cur_mpp; mpv = cur_mpv; spv = cur_spv; sp2v = cur_sp2v; sp2p = cur_sp2p;
    if (mret_req) begin
      if (cur_priv == 2'd3) begin
        c = 1;
        k = spec_new ? 3 : int'(cur_mpp);
        ie[k] = cur_mpie;
        mpie = 1; mpp = 2'd0; mpv = 0; p = cur_mpp;
        if (hh) begin v = cur_mpv; sw = cur_mpv; end
      end else il = 1;
    end else if (sret_req) begin
      if (cur_priv != 2'd0) begin
        c = 1;
        p = {1'b0, cur_spp};
        if (hh && !cur_virt) begin
          ie[1] = cur_spie; spie = 1;
          spv = cur_sp2v; spp = cur_sp2p; sp2v = 0; sp2p = 0;
          v = cur_spv; sw = cur_spv;
        end else begin
          k = spec_new ? 1 : int'(cur_spp);
          ie[k] = cur_spie; spie = 1; spp = 0;
        end
      end else il = 1;
    end
    if (c) held = {p, v, ie, spie, spp, mpie, mpp, mpv, spv, sp2v, sp2p};
    expv = {c, il, sw, held};
  endtask

  function automatic string tag_of();
    if (mret_req && sret_req) return "R4";
    if (mret_req) return (cur_priv == 2'd3) ? "R5/R6/R9/R11" : "R3";
    if (sret_req) begin
      if (cur_priv == 2'd0) return "R2";
      return cur_virt ? "R7/R9/R11" : "R8/R7/R9/R11";
    end
    return "R1";
  endfunction

  initial begin
    {sret_req, mret_req, spec_new, cur_priv, cur_virt, cur_ie, cur_spie, cur_spp,
     cur_mpie, cur_mpp, cur_mpv, cur_spv, cur_sp2v, cur_sp2p} = '0;
    repeat (3) @(negedge clk);
    // R10: reset values.
    check(act_h, {3'b000, 2'd3, 14'd0}, "R10", "hyp");
    check(act_n, {3'b000, 2'd3, 14'd0}, "R10", "nohyp");
    held_h = {2'd3, 14'd0};
    held_n = {2'd3, 14'd0};
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(act_h, exp_h, pend_tag, "hyp");
        check(act_n, exp_n, pend_tag, "nohyp");
      end
      begin
        logic [15:0] v;
        v = i[15:0];
        sret_req = v[0];  mret_req = v[1];  spec_new = v[2];
        cur_priv = v[4:3]; cur_virt = v[5];
        cur_ie   = v[6] ? 4'hA : 4'h5;
        cur_spie = v[7];  cur_spp = v[8];  cur_mpie = v[9];
        cur_mpp  = v[11:10]; cur_mpv = v[12];
        cur_spv  = v[13]; cur_sp2v = v[14]; cur_sp2p = v[15];
      end
      pend_tag = tag_of();
      model(1'b1, held_h, exp_h);
      model(1'b0, held_n, exp_n);
    end
    @(negedge clk);
    check(act_h, exp_h, pend_tag, "hyp");
    check(act_n, exp_n, pend_tag, "nohyp");
    // R1: idle after the sweep holds state and keeps strobes low.
    sret_req = 0; mret_req = 0;
    pend_tag = tag_of();
    model(1'b1, held_h, exp_h);
    model(1'b0, held_n, exp_n);
    @(negedge clk);
    check(act_h, exp_h, "R1", "hyp");
    check(act_n, exp_n, "R1", "nohyp");
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule